// File: doc/BRIEF.md
# Infrared Remote Transmit Buffer Controller

This block drives a single infrared transmit pin from a 128-bit payload. A host fills sixteen byte registers and a few configuration fields through a simple write port, then issues a send command. The payload is copied as a whole into an internal shift buffer. One bit goes out per bit-period tick, most significant bit of byte 0 first, and a high tail segment of programmable length follows. Carrier modulation and the pulse shaping of each bit belong to the logic downstream.

In single mode a programmed number of bits goes out, then the tail, and the pin returns low. In repeat mode the full 128-bit payload is reloaded into the buffer after every pass, so the output never stops until repeat is switched off. An interrupt flag records that the buffer is empty. It drives an active-low pin when enabled. A soft-reset bit resets the whole block and stays set until the host bus reports a STOP condition, which reaches the block as a one-cycle strobe.

Top module: `ir_tx_ctrl`

## Requirements
- R1: Addresses 0x00 to 0x0F hold payload bytes 0 to 15. The serial order is byte 0 bit 7 first, down to byte 15 bit 0.
- R2: While a transfer is active, the output changes only at the clock edge that follows a cycle with bit_tick high. The first bit appears on the edge that loads the buffer.
- R3: In single mode the bit-length field (address 0x11, bits 6:0) holds n, and exactly n+1 payload bits are sent.
- R4: After the last data bit in single mode, ir_out is high for the number of ticks in the tail field (address 0x12, 0 to 255), then low. A tail of 0 goes low immediately.
- R5: With repeat set (control 0x10, bit 3), every pass is 128 bits and the payload is reloaded at once, with no interrupt between passes. If repeat is cleared during a pass, that pass completes and the tail follows.
- R6: Send is control bit 0, a write-one command. When the block is idle, the load happens on the edge of the write. A send during a transfer or tail is held and loads on the cycle after the block returns to idle.
- R7: The empty flag is set after reset and on the tick that drains the last single-mode bit. It is cleared by a load or by writing control bit 1. A drain in the same cycle as the clear takes priority.
- R8: irq_n is low exactly when the empty flag is set and the enable (control bit 2) is 1. With the enable at 0, irq_n is high.
- R9: Writing 1 to bit 0 of address 0x13 at once returns every register and the engine to reset values (payload 0, bit length 127, tail 0, enable and repeat 0, flag set). The block stays so, ignoring all other writes, until bus_stop is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| bus_stop | input | 1 | One-cycle strobe marking the end of a host bus transaction |
| bit_tick | input | 1 | Bit-period tick, one cycle wide |
| ir_out | output | 1 | Serial infrared output |
| irq_n | output | 1 | Active-low buffer-empty interrupt |

## Verification
The hardest case to reach is a send that arrives while the previous transfer is still shifting. The held request has to survive the rest of the data and the whole tail, then load exactly one idle cycle later. The bench issues a second send two ticks into a short four-bit transfer and checks the idle low cycle and the reloaded first bit. It also clears the repeat bit in the middle of a second repeat pass, which shows that the pass completes before the tail begins.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
    localparam int NBYTES = 16;
    localparam int BYTE_W = 8;
    localparam int PAY_W  = NBYTES * BYTE_W;
    localparam int CNT_W  = $clog2(PAY_W);
    localparam int TAIL_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h10;
    localparam logic [ADDR_W-1:0] A_BLEN = 5'h11;
    localparam logic [ADDR_W-1:0] A_TAIL = 5'h12;
    localparam logic [ADDR_W-1:0] A_SRST = 5'h13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } eng_st_e;
endpackage

// File: rtl/irtx_regs.sv
module irtx_regs
    import irtx_pkg::*;
#(
    parameter int NB   = NBYTES,
    parameter int CW   = CNT_W,
    parameter int TW   = TAIL_W,
    parameter int AW   = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [7:0]          wr_data,
    output logic [NB*8-1:0]     payload,
    output logic [CW-1:0]       bitlen,
    output logic [TW-1:0]       taillen,
    output logic                irq_en,
    output logic                rep_en
);
    typedef struct packed {
        logic [NB-1:0][7:0] pay;
        logic [CW-1:0]      blen;
        logic [TW-1:0]      tail;
        logic               ie;
        logic               rep;
    } regs_t;

    localparam regs_t REGS_RST = '{
        pay:  '0,
        blen: {CW{1'b1}},
        tail: '0,
        ie:   1'b0,
        rep:  1'b0
    };

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int k = 0; k < NB; k++) begin
                if (wr_addr == AW'(k)) regs_d.pay[NB-1-k] = wr_data;
            end
            if (wr_addr == A_CTRL) begin
                regs_d.ie  = wr_data[2];
                regs_d.rep = wr_data[3];
            end
            if (wr_addr == A_BLEN) regs_d.blen = wr_data[CW-1:0];
            if (wr_addr == A_TAIL) regs_d.tail = wr_data[TW-1:0];
        end
        if (clr) regs_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign payload = regs_q.pay;
    assign bitlen  = regs_q.blen;
    assign taillen = regs_q.tail;
    assign irq_en  = regs_q.ie;
    assign rep_en  = regs_q.rep;
endmodule

// File: rtl/irtx_engine.sv
module irtx_engine
    import irtx_pkg::*;
#(
    parameter int PW = PAY_W,
    parameter int CW = CNT_W,
    parameter int TW = TAIL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            send,
    input  logic            irq_clr,
    input  logic            tick,
    input  logic            rep_en,
    input  logic [CW-1:0]   bitlen,
    input  logic [TW-1:0]   taillen,
    input  logic [PW-1:0]   payload,
    output logic            ir_out,
    output logic            empty_flag,
    output logic            busy,
    output logic            load
);
    localparam logic [CW-1:0] FULL_PASS = CW'(PW - 1);

    typedef struct packed {
        eng_st_e        st;
        logic [PW-1:0]  sh;
        logic [CW-1:0]  left;
        logic [TW-1:0]  tcnt;
        logic           pend;
        logic           flag;
    } eng_t;

    localparam eng_t ENG_RST = '{
        st:   ST_IDLE,
        sh:   '0,
        left: '0,
        tcnt: '0,
        pend: 1'b0,
        flag: 1'b1
    };

    eng_t eng_d, eng_q;
    logic drain;

    always_comb begin
        eng_d = eng_q;
        load  = 1'b0;
        drain = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (send || eng_q.pend) load = 1'b1;
            end
            ST_DATA: begin
                if (send) eng_d.pend = 1'b1;
                if (tick) begin
                    eng_d.sh   = eng_q.sh << 1;
                    eng_d.left = eng_q.left - 1'b1;
                    if (eng_q.left == '0) begin
                        if (rep_en) begin
                            eng_d.sh   = payload;
                            eng_d.left = FULL_PASS;
                        end else begin
                            drain = 1'b1;
                            if (taillen == '0) begin
                                eng_d.st = ST_IDLE;
                            end else begin
                                eng_d.st   = ST_TAIL;
                                eng_d.tcnt = taillen;
                            end
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (send) eng_d.pend = 1'b1;
                if (tick) begin
                    eng_d.tcnt = eng_q.tcnt - 1'b1;
                    if (eng_q.tcnt == TW'(1)) eng_d.st = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase

        if (load) begin
            eng_d.st   = ST_DATA;
            eng_d.sh   = payload;
            eng_d.left = rep_en ? FULL_PASS : bitlen;
            eng_d.pend = 1'b0;
        end

        if (load)         eng_d.flag = 1'b0;
        else if (drain)   eng_d.flag = 1'b1;
        else if (irq_clr) eng_d.flag = 1'b0;

        if (clr) eng_d = ENG_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    always_comb begin
        case (eng_q.st)
            ST_DATA: ir_out = eng_q.sh[PW-1];
            ST_TAIL: ir_out = 1'b1;
            default: ir_out = 1'b0;
        endcase
    end

    assign empty_flag = eng_q.flag;
    assign busy       = (eng_q.st != ST_IDLE);
endmodule

// File: rtl/ir_tx_ctrl.sv
module ir_tx_ctrl
    import irtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              bus_stop,
    input  logic              bit_tick,
    output logic              ir_out,
    output logic              irq_n
);
    logic srst_d, srst_q;
    logic srst_wr, clr_all, wr_ok, ctrl_wr;
    logic send_cmd, irqc_cmd;

    logic [PAY_W-1:0]  payload_w;
    logic [CNT_W-1:0]  bitlen_w;
    logic [TAIL_W-1:0] taillen_w;
    logic              irq_en_w, rep_en_w;
    logic              flag_w, busy_w, load_w;

    assign srst_wr  = wr_en && (wr_addr == A_SRST) && wr_data[0];
    assign clr_all  = srst_q || srst_wr;
    assign wr_ok    = wr_en && !srst_q;
    assign ctrl_wr  = wr_ok && (wr_addr == A_CTRL);
    assign send_cmd = ctrl_wr && wr_data[0];
    assign irqc_cmd = ctrl_wr && wr_data[1];

    always_comb begin
        srst_d = srst_q || srst_wr;
        if (bus_stop) srst_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= srst_d;
    end

    irtx_regs #(
        .NB (NBYTES),
        .CW (CNT_W),
        .TW (TAIL_W),
        .AW (ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_all),
        .wr_en   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .payload (payload_w),
        .bitlen  (bitlen_w),
        .taillen (taillen_w),
        .irq_en  (irq_en_w),
        .rep_en  (rep_en_w)
    );

    irtx_engine #(
        .PW (PAY_W),
        .CW (CNT_W),
        .TW (TAIL_W)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_all),
        .send       (send_cmd),
        .irq_clr    (irqc_cmd),
        .tick       (bit_tick),
        .rep_en     (rep_en_w),
        .bitlen     (bitlen_w),
        .taillen    (taillen_w),
        .payload    (payload_w),
        .ir_out     (ir_out),
        .empty_flag (flag_w),
        .busy       (busy_w),
        .load       (load_w)
    );

    assign irq_n = !(flag_w && irq_en_w);
endmodule

// File: rtl/irtx_chk.sv
module irtx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic bus_stop,
    input logic bit_tick,
    input logic ir_out,
    input logic irq_n,
    input logic srst_q,
    input logic eng_busy,
    input logic eng_load
);
    // R2: output holds between ticks while busy
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !bit_tick && !wr_en) |=> $stable(ir_out));

    // R7: a load clears the interrupt
    a_r7_load_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load |=> irq_n);

    // R9: STOP releases soft reset
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !srst_q);

    // R9: quiet pins while soft reset is held
    a_r9_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (!ir_out && irq_n));
endmodule

bind ir_tx_ctrl irtx_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .bus_stop (bus_stop),
    .bit_tick (bit_tick),
    .ir_out   (ir_out),
    .irq_n    (irq_n),
    .srst_q   (srst_q),
    .eng_busy (busy_w),
    .eng_load (load_w)
);

// File: tb/ir_tx_ctrl_tb_top.sv
module ir_tx_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       bus_stop = 1'b0;
    logic       bit_tick = 1'b0;
    logic       ir_out, irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [7:0] tb_pay [16];

    // reference model state
    logic [7:0] m_pay [16];
    int  m_bl, m_el, m_st, m_tn;
    bit  m_ie, m_rep, m_flag, m_pend, m_srst;
    bit  m_q [$];

    always #10 clk = ~clk;

    ir_tx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bus_stop(bus_stop), .bit_tick(bit_tick),
        .ir_out(ir_out), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        foreach (m_pay[k]) m_pay[k] = 8'h00;
        m_bl = 127; m_el = 0; m_ie = 0; m_rep = 0;
        m_st = 0; m_tn = 0; m_flag = 1; m_pend = 0;
        m_q.delete();
    endtask

    task automatic m_fill(input int n);
        m_q.delete();
        for (int i = 0; i < n; i++) m_q.push_back(m_pay[i / 8][7 - (i % 8)]);
    endtask

    function automatic bit m_ir();
        if (m_st == 1) return m_q[0];
        return (m_st == 2);
    endfunction

    always @(posedge clk) begin
        bit s_wr, snd, iclr, ld, dr;
        if (!rst_n) begin
            m_reset();
            m_srst = 0;
        end else begin
            s_wr = wr_en && wr_addr == 5'h13 && wr_data[0];
            if (m_srst || s_wr) begin
                m_reset();
                m_srst = !bus_stop;
            end else begin
                snd  = wr_en && wr_addr == 5'h10 && wr_data[0];
                iclr = wr_en && wr_addr == 5'h10 && wr_data[1];
                ld = 0; dr = 0;
                if (m_st == 0) begin
                    if (snd || m_pend) ld = 1;
                end else begin
                    if (snd) m_pend = 1;
                    if (bit_tick) begin
                        if (m_st == 1) begin
                            void'(m_q.pop_front());
                            if (m_q.size() == 0) begin
                                if (m_rep) m_fill(128);
                                else begin
                                    dr = 1;
                                    if (m_el == 0) m_st = 0;
                                    else begin m_st = 2; m_tn = m_el; end
                                end
                            end
                        end else begin
                            m_tn--;
                            if (m_tn == 0) m_st = 0;
                        end
                    end
                end
                if (ld) begin
                    m_st = 1;
                    m_fill(m_rep ? 128 : m_bl + 1);
                    m_pend = 0;
                end
                if (ld) m_flag = 0;
                else if (dr) m_flag = 1;
                else if (iclr) m_flag = 0;
                if (wr_en) begin
                    if (wr_addr < 5'd16) m_pay[wr_addr[3:0]] = wr_data;
                    else if (wr_addr == 5'h10) begin m_ie = wr_data[2]; m_rep = wr_data[3]; end
                    else if (wr_addr == 5'h11) m_bl = int'(wr_data[6:0]);
                    else if (wr_addr == 5'h12) m_el = int'(wr_data);
                end
            end
        end
    end

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ir_out == m_ir(), cur_req, "model ir_out", int'(ir_out), int'(m_ir()));
            chk(irq_n == !(m_flag && m_ie), "R8", "model irq_n", int'(irq_n),
                int'(!(m_flag && m_ie)));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    function automatic bit pb(input int i);
        return tb_pay[(i % 128) / 8][7 - (i % 8)];
    endfunction

    task automatic run_bits(input int n, input int start, input string req);
        for (int i = 0; i < n; i++) begin
            chk(ir_out == pb(start + i), req, "data bit", int'(ir_out), int'(pb(start + i)));
            tk();
        end
    endtask

    task automatic run_tail(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(ir_out == 1'b1, req, "tail high", int'(ir_out), 1);
            tk();
        end
        chk(ir_out == 1'b0, req, "low after tail", int'(ir_out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired act=0 exp=1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(irq_n == 1'b1, "R8", "reset irq_n", int'(irq_n), 1);
        chk(ir_out == 1'b0, "R4", "reset ir_out", int'(ir_out), 0);
        wr(5'h10, 8'h04);
        chk(irq_n == 1'b0, "R7", "empty after reset", int'(irq_n), 0);

        // R1 R3 R4: twelve bits, three tail ticks
        cur_req = "R3";
        for (int k = 0; k < 16; k++) begin
            tb_pay[k] = 8'(k * 37 + 200);
            wr(5'(k), tb_pay[k]);
        end
        wr(5'h11, 8'd11);
        wr(5'h12, 8'd3);
        wr(5'h10, 8'h05);
        chk(irq_n == 1'b1, "R7", "load clears irq", int'(irq_n), 1);
        chk(ir_out == pb(0), "R1", "first bit byte0 bit7", int'(ir_out), int'(pb(0)));
        run_bits(12, 0, "R3");
        cur_req = "R4";
        run_tail(3, "R4");
        chk(irq_n == 1'b0, "R7", "drain sets irq", int'(irq_n), 0);

        // R8 masking, R7 clear
        wr(5'h10, 8'h00);
        chk(irq_n == 1'b1, "R8", "masked", int'(irq_n), 1);
        wr(5'h10, 8'h04);
        chk(irq_n == 1'b0, "R8", "unmasked", int'(irq_n), 0);
        wr(5'h10, 8'h06);
        chk(irq_n == 1'b1, "R7", "irqc clears", int'(irq_n), 1);

        // R1 full 128 bits, zero tail
        cur_req = "R1";
        wr(5'h11, 8'd127);
        wr(5'h12, 8'd0);
        wr(5'h10, 8'h05);
        run_bits(128, 0, "R1");
        run_tail(0, "R4");
        chk(irq_n == 1'b0, "R7", "drain after 128", int'(irq_n), 0);

        // R5 repeat mode
        cur_req = "R5";
        wr(5'h11, 8'd5);
        wr(5'h12, 8'd2);
        wr(5'h10, 8'h0C);
        wr(5'h10, 8'h0D);
        run_bits(128, 0, "R5");
        run_bits(40, 0, "R5");
        chk(irq_n == 1'b1, "R5", "no irq on reload", int'(irq_n), 1);
        wr(5'h10, 8'h04);
        run_bits(88, 40, "R5");
        run_tail(2, "R5");
        chk(irq_n == 1'b0, "R5", "irq after last pass", int'(irq_n), 0);

        // R6 send held during a transfer
        cur_req = "R6";
        wr(5'h11, 8'd3);
        wr(5'h10, 8'h05);
        run_bits(2, 0, "R6");
        wr(5'h10, 8'h05);
        run_bits(2, 2, "R6");
        run_tail(2, "R6");
        @(negedge clk);
        chk(ir_out == pb(0), "R6", "held send reloads", int'(ir_out), int'(pb(0)));
        run_bits(4, 0, "R6");
        run_tail(2, "R6");

        // R9 soft reset
        cur_req = "R9";
        wr(5'h11, 8'd127);
        wr(5'h10, 8'h05);
        run_bits(5, 0, "R9");
        wr(5'h13, 8'h01);
        chk(ir_out == 1'b0, "R9", "srst output low", int'(ir_out), 0);
        chk(irq_n == 1'b1, "R9", "srst irq masked", int'(irq_n), 1);
        wr(5'h00, 8'hFF);
        wr(5'h10, 8'h05);
        chk(ir_out == 1'b0, "R9", "send ignored in srst", int'(ir_out), 0);
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        wr(5'h10, 8'h04);
        chk(irq_n == 1'b0, "R9", "flag set after srst", int'(irq_n), 0);
        for (int k = 0; k < 16; k++) tb_pay[k] = 8'h00;
        wr(5'h10, 8'h05);
        run_bits(8, 0, "R9");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule